// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, made of a 16-bit segment selector and an offset, into a flat linear address. It works in one of two modes, chosen per request. In real mode the selector is shifted left by four bits and added to the low 16 bits of the offset, which covers a space of about one megabyte. That result is ready two clock edges after the request is taken.

In protected mode the selector picks one 8-byte descriptor from one of two in-memory tables. The global table is used when the table-select bit is clear and the local table when it is set. The block fetches the descriptor as two 32-bit words through a plain read port. It then assembles the segment base and limit from the split descriptor fields, adds the base to the offset, and flags a fault when the offset lies beyond the limit. A request is a single-cycle strobe. The block only accepts a strobe while it is idle, and it signals completion with a one-cycle pulse. Its results hold until the next completion.

Top module: `seg_addr_xlate`

## Requirements
- R1: With `protMode` low, the result is `linAddr = selector*16 + offset[15:0]`, zero-extended. Bits 31:16 of the offset have no effect, `fault` is 0, and `done` rises one clock after the accepting edge.
- R2: With `protMode` high, selector bits 15:3 are the descriptor index and bit 2 picks the table: 0 uses `gdtBase`, 1 uses `ldtBase`. Bits 1:0 have no effect on the result.
- R3: The descriptor is read on two consecutive cycles. The first read is at table base + index*8 and the second is at that address + 4. Read data is taken the cycle after `memRdEn`.
- R4: The base is built as {word at +4 bits 31:24, word at +4 bits 7:0, first word bits 31:16}, and `linAddr` = base + offset modulo 2^32.
- R5: The 20-bit limit is {word at +4 bits 19:16, first word bits 15:0}. With the granularity bit (bit 23 of the word at +4) clear, the limit counts bytes. `fault` is 1 exactly when offset > limit, so offset == limit does not fault.
- R6: With the granularity bit set, the effective limit is limit*4096 + 4095. A flat descriptor (base 0, limit 0xFFFFF, granularity set) gives `linAddr` = offset and never faults.
- R7: In protected mode, `done` rises four clocks after the accepting edge, and `done` is always a single-cycle pulse.
- R8: A request strobe while `busy` is high is ignored: no extra `done`, and the result of the running request is unchanged.
- R9: After reset, `done`, `fault`, `busy` and `memRdEn` are 0 and `linAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| protMode | input | 1 | 1 = protected-mode translation, 0 = real mode |
| selector | input | 16 | Segment selector |
| offset | input | 32 | Offset within the segment |
| gdtBase | input | 32 | Byte address of the global descriptor table |
| ldtBase | input | 32 | Byte address of the local descriptor table |
| memRdEn | output | 1 | Descriptor read strobe |
| memAddr | output | 32 | Descriptor read byte address |
| memRdData | input | 32 | Read data, valid the cycle after `memRdEn` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| linAddr | output | 32 | Translated linear address |
| fault | output | 1 | Offset beyond segment limit (protected mode) |

## Verification
The bench targets the limit boundary on both sides, with the granularity bit clear and set. A design that uses >= instead of >, or that ignores scaling, faults on a legal last byte or lets one byte too many through. Requests with the table-select bit set, with nonzero privilege bits, and with junk in the upper offset bits in real mode expose a wrong table choice, index bits that include the privilege field, or a real-mode sum that is not truncated to 16 offset bits. A base that makes the sum wrap past 2^32, split-field descriptors, and a strobe sent mid-fetch catch base fields assembled in the wrong order, a second read at the wrong address, and a request that restarts or corrupts the running one.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_WAIT_HI,
    ST_FINISH
  } xlateState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptReq;  // latch request fields
    logic addrHi;     // drive address of the upper descriptor word
    logic grabLo;     // capture lower descriptor word
    logic grabHi;     // capture upper descriptor word
    logic commit;     // load result registers
  } xlateStrobe_t;

  localparam int DESC_BYTES  = 8;
  localparam int WORD_BYTES  = 4;
  localparam int LIM_W       = 20;
  localparam int GRAN_SHIFT  = 12;
  localparam int GRAN_BIT    = 23;

  function automatic logic [31:0] descBase(input logic [31:0] lo, input logic [31:0] hi);
    return {hi[31:24], hi[7:0], lo[31:16]};
  endfunction

  function automatic logic [LIM_W-1:0] descLimit(input logic [31:0] lo, input logic [31:0] hi);
    return {hi[19:16], lo[15:0]};
  endfunction

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         protMode,
  output xlateStrobe_t strobe,
  output logic         busy,
  output logic         memRdEn,
  output logic         done
);

  xlateState_t stateQ, stateD;
  logic        accept;
  logic        doneQ;

  assign accept = reqValid && (stateQ == ST_IDLE);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:    if (accept) stateD = protMode ? ST_RD_LO : ST_FINISH;
      ST_RD_LO:   stateD = ST_RD_HI;
      ST_RD_HI:   stateD = ST_WAIT_HI;
      ST_WAIT_HI: stateD = ST_FINISH;
      ST_FINISH:  stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= (stateQ == ST_FINISH);
    end
  end

  always_comb begin
    strobe.acceptReq = accept;
    strobe.addrHi    = (stateQ == ST_RD_HI);
    strobe.grabLo    = (stateQ == ST_RD_HI);
    strobe.grabHi    = (stateQ == ST_WAIT_HI);
    strobe.commit    = (stateQ == ST_FINISH);
  end

  assign memRdEn = (stateQ == ST_RD_LO) || (stateQ == ST_RD_HI);
  assign busy    = (stateQ != ST_IDLE);
  assign done    = doneQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_REAL_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !protMode) |-> ##2 done); // R1
  AST_PROT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && protMode) |-> ##5 done); // R7
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEL_W      = 16,
  parameter int REAL_SHIFT = 4,
  parameter bit HONOR_GRAN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobe_t      strobe,
  input  logic              protMode,
  input  logic [SEL_W-1:0]  selector,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [31:0]       memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] linAddr,
  output logic              fault
);

  localparam int TI_BIT  = 2;
  localparam int IDX_LSB = 3;
  localparam int IDX_W   = SEL_W - IDX_LSB;
  localparam int REAL_W  = SEL_W + REAL_SHIFT + 1;
  localparam int DESC_SH = $clog2(DESC_BYTES);

  logic              modeQ;
  logic [SEL_W-1:0]  selQ;
  logic [ADDR_W-1:0] offQ;
  logic [ADDR_W-1:0] tblBaseQ;
  logic [31:0]       wordLoQ, wordHiQ;
  logic [ADDR_W-1:0] linQ;
  logic              faultQ;

  logic [ADDR_W-1:0] descAddr;
  logic [REAL_W-1:0] realSum;
  logic [ADDR_W-1:0] segBase;
  logic [LIM_W-1:0]  rawLimit;
  logic [ADDR_W-1:0] effLimit;

  // request capture, table chosen by TI bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      selQ     <= '0;
      offQ     <= '0;
      tblBaseQ <= '0;
    end else if (strobe.acceptReq) begin
      modeQ    <= protMode;
      selQ     <= selector;
      offQ     <= offset;
      tblBaseQ <= selector[TI_BIT] ? ldtBase : gdtBase;
    end
  end

  assign descAddr = tblBaseQ +
                    {{(ADDR_W-IDX_W-DESC_SH){1'b0}}, selQ[SEL_W-1:IDX_LSB], {DESC_SH{1'b0}}};
  assign memAddr  = strobe.addrHi ? descAddr + ADDR_W'(WORD_BYTES) : descAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordLoQ <= '0;
      wordHiQ <= '0;
    end else begin
      if (strobe.grabLo) wordLoQ <= memRdData;
      if (strobe.grabHi) wordHiQ <= memRdData;
    end
  end

  assign realSum  = {1'b0, selQ, {REAL_SHIFT{1'b0}}} +
                    {{(REAL_SHIFT+1){1'b0}}, offQ[SEL_W-1:0]};
  assign segBase  = ADDR_W'(descBase(wordLoQ, wordHiQ));
  assign rawLimit = descLimit(wordLoQ, wordHiQ);

  generate
    if (HONOR_GRAN) begin : g_gran
      always_comb begin
        if (wordHiQ[GRAN_BIT])
          effLimit = {{(ADDR_W-LIM_W-GRAN_SHIFT){1'b0}}, rawLimit, {GRAN_SHIFT{1'b1}}};
        else
          effLimit = {{(ADDR_W-LIM_W){1'b0}}, rawLimit};
      end
    end else begin : g_bytes
      assign effLimit = {{(ADDR_W-LIM_W){1'b0}}, rawLimit};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linQ   <= '0;
      faultQ <= 1'b0;
    end else if (strobe.commit) begin
      if (modeQ) begin
        linQ   <= segBase + offQ;
        faultQ <= (offQ > effLimit);
      end else begin
        linQ   <= {{(ADDR_W-REAL_W){1'b0}}, realSum};
        faultQ <= 1'b0;
      end
    end
  end

  assign linAddr = linQ;
  assign fault   = faultQ;

  AST_REAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !modeQ) |=> !fault); // R1
  AST_FLAT_IDENTITY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && modeQ && segBase == '0 && wordHiQ[GRAN_BIT] && rawLimit == '1)
      |=> (linAddr == $past(offQ) && !fault)); // R6
  AST_GRABS_ORDERED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.grabLo |=> strobe.grabHi); // R3

endmodule

// File: rtl/seg_addr_xlate.sv
module seg_addr_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SEL_W      = 16,
  parameter int REAL_SHIFT = 4,
  parameter bit HONOR_GRAN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              protMode,
  input  logic [SEL_W-1:0]  selector,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [ADDR_W-1:0] ldtBase,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [31:0]       memRdData,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] linAddr,
  output logic              fault
);

  xlateStrobe_t strobe;

  seg_xlate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .protMode (protMode),
    .strobe   (strobe),
    .busy     (busy),
    .memRdEn  (memRdEn),
    .done     (done)
  );

  seg_xlate_dp #(
    .ADDR_W     (ADDR_W),
    .SEL_W      (SEL_W),
    .REAL_SHIFT (REAL_SHIFT),
    .HONOR_GRAN (HONOR_GRAN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .protMode  (protMode),
    .selector  (selector),
    .offset    (offset),
    .gdtBase   (gdtBase),
    .ldtBase   (ldtBase),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .linAddr   (linAddr),
    .fault     (fault)
  );

  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> memAddr == $past(memAddr) + ADDR_W'(WORD_BYTES)); // R3
  AST_NO_READ_REAL: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !protMode) |=> !memRdEn); // R1

endmodule

// File: tb/seg_addr_xlate_test.sv
module seg_addr_xlate_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        protMode = 1'b0;
  logic [15:0] selector = '0;
  logic [31:0] offset = '0;
  logic [31:0] gdtBase = 32'h0000_0100;
  logic [31:0] ldtBase = 32'h0000_0200;
  logic        memRdEn;
  logic [31:0] memAddr;
  logic [31:0] memRdData = '0;
  logic        busy, done, fault;
  logic [31:0] linAddr;

  int checks = 0;
  int fails  = 0;

  logic [31:0] memArr [0:255];
  logic [31:0] addrA = '0, addrB = '0;

  always #2 clk = ~clk;  // 250 MHz

  seg_addr_xlate uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .protMode(protMode),
    .selector(selector), .offset(offset), .gdtBase(gdtBase), .ldtBase(ldtBase),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .busy(busy), .done(done), .linAddr(linAddr), .fault(fault)
  );

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memArr[memAddr[9:2]];
      addrA <= addrB;
      addrB <= memAddr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic putDesc(input int byteAddr, input logic [31:0] base, input logic [19:0] lim, input bit g);
    memArr[byteAddr[9:2]]     = {base[15:0], lim[15:0]};
    memArr[byteAddr[9:2] + 1] = {base[31:24], g, 3'b100, lim[19:16], 8'h92, base[23:16]};
  endtask

  // issue one request, return result and latency in negedges
  task automatic doReq(input bit pm, input logic [15:0] sel, input logic [31:0] off,
                       output logic [31:0] lin, output logic flt, output int lat);
    @(negedge clk);
    reqValid = 1'b1; protMode = pm; selector = sel; offset = off;
    lat = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
      if (done) break;
    end
    lin = linAddr; flt = fault;
    @(negedge clk);
    chk(done == 1'b0, "R7 done pulse width", {31'b0, done}, 32'h0);
  endtask

  task automatic testReset();
    chk(done == 0 && fault == 0 && busy == 0 && memRdEn == 0, "R9 reset flags",
        {28'b0, done, fault, busy, memRdEn}, 32'h0);
    chk(linAddr == 32'h0, "R9 reset linAddr", linAddr, 32'h0);
  endtask

  task automatic testReal();
    logic [31:0] l; logic f; int lat;
    doReq(1'b0, 16'h1000, 32'h0000_0010, l, f, lat);
    chk(l == 32'h0001_0010, "R1 real basic", l, 32'h0001_0010);
    chk(lat == 2, "R1 real latency", lat, 2);
    chk(f == 1'b0, "R1 real no fault", {31'b0, f}, 0);
    doReq(1'b0, 16'hFFFF, 32'h0000_FFFF, l, f, lat);
    chk(l == 32'h0010_FFEF, "R1 real top carry", l, 32'h0010_FFEF);
    doReq(1'b0, 16'h0001, 32'hABCD_0005, l, f, lat);
    chk(l == 32'h0000_0015, "R1 real upper offset ignored", l, 32'h15);
  endtask

  task automatic testTables();
    logic [31:0] l; logic f; int lat;
    putDesc(32'h100 + 3*8, 32'h1234_5678, 20'h00FFF, 1'b0);
    putDesc(32'h200 + 3*8, 32'h0A0B_0C0D, 20'h00FFF, 1'b0);
    doReq(1'b1, {13'd3, 1'b0, 2'b11}, 32'h10, l, f, lat);
    chk(l == 32'h1234_5688, "R2 R4 gdt base add", l, 32'h1234_5688);
    chk(f == 1'b0, "R5 inside limit", {31'b0, f}, 0);
    chk(lat == 5, "R7 protected latency", lat, 5);
    chk(addrA == 32'h118, "R3 first read address", addrA, 32'h118);
    chk(addrB == 32'h11C, "R3 second read address", addrB, 32'h11C);
    doReq(1'b1, {13'd3, 1'b1, 2'b00}, 32'h20, l, f, lat);
    chk(l == 32'h0A0B_0C2D, "R2 ldt selected", l, 32'h0A0B_0C2D);
    chk(addrA == 32'h218, "R2 R3 ldt read address", addrA, 32'h218);
  endtask

  task automatic testLimits();
    logic [31:0] l; logic f; int lat;
    putDesc(32'h100 + 5*8, 32'h0000_4000, 20'h00123, 1'b0);
    doReq(1'b1, {13'd5, 3'b000}, 32'h123, l, f, lat);
    chk(f == 1'b0, "R5 offset equals limit", {31'b0, f}, 0);
    doReq(1'b1, {13'd5, 3'b000}, 32'h124, l, f, lat);
    chk(f == 1'b1, "R5 offset past limit", {31'b0, f}, 1);
    putDesc(32'h100 + 6*8, 32'h0000_0000, 20'h00001, 1'b1);
    doReq(1'b1, {13'd6, 3'b000}, 32'h1FFF, l, f, lat);
    chk(f == 1'b0, "R6 scaled limit last byte", {31'b0, f}, 0);
    doReq(1'b1, {13'd6, 3'b000}, 32'h2000, l, f, lat);
    chk(f == 1'b1, "R6 scaled limit exceeded", {31'b0, f}, 1);
    putDesc(32'h100 + 1*8, 32'h0000_0000, 20'hFFFFF, 1'b1);
    doReq(1'b1, {13'd1, 3'b000}, 32'hFFFF_FFFF, l, f, lat);
    chk(l == 32'hFFFF_FFFF && f == 1'b0, "R6 flat segment", l, 32'hFFFF_FFFF);
    putDesc(32'h100 + 7*8, 32'hFFFF_FFF0, 20'hFFFFF, 1'b1);
    doReq(1'b1, {13'd7, 3'b000}, 32'h20, l, f, lat);
    chk(l == 32'h0000_0010, "R4 base wrap", l, 32'h10);
  endtask

  task automatic testBusy();
    int doneCnt = 0;
    @(negedge clk);
    reqValid = 1'b1; protMode = 1'b1; selector = {13'd3, 3'b000}; offset = 32'h40;
    @(negedge clk);
    protMode = 1'b0; selector = 16'h0002; offset = 32'h1;  // strobe held while busy
    @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (done) begin
        doneCnt++;
        chk(linAddr == 32'h1234_56B8, "R8 busy request ignored", linAddr, 32'h1234_56B8);
      end
      @(negedge clk);
    end
    chk(doneCnt == 1, "R8 single completion", doneCnt, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) memArr[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReal();
    testTables();
    testLimits();
    testBusy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule